// File: doc/BRIEF.md
# Eight-bit bidirectional I/O port with pin readback

The block is one general-purpose port of eight pins on a simple synchronous register bus. Software sets a direction bit per pin. When the bit is 1, the pin is driven from an output latch. When the bit is 0, the pin is left undriven. Every pin level passes through a two-stage synchronizer before any register can see it.

The data register reads back per bit. A pin set as output returns its latch value, and a pin set as input returns the synchronized level. A separate read-only register always returns the synchronized levels. A per-pin enable hands a pin to an on-chip timer channel. That channel then supplies the output value and output enable in place of the GPIO latch and direction bit.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), the data latch, the direction register and the synchronizer stages are zero. As a result pin_oe is 0, pin_out is 0 on pins with tmr_en low, and every register reads 0.
- R2: A write (bus_sel=1, bus_wr=1) at address 0 loads the data latch and at address 1 loads the direction register, on the same clock edge. A direction bit of 1 means output and 0 means input.
- R3: For a pin with tmr_en low, pin_oe equals its direction bit, registered once more. pin_oe therefore changes on the clock edge after the edge that wrote the direction register.
- R4: Reading address 0 returns, per bit, the data latch where the direction bit is 1 and the synchronized pin level where it is 0.
- R5: A change on pin_in shows up in the address 2 read value after exactly two rising clock edges.
- R6: Address 2 returns the synchronized pin levels whatever the direction bits and timer enables are. Writes to address 2 change no register.
- R7: Address 3 reads 0, and writes to it change no register.
- R8: For a pin with tmr_en high, pin_out follows tmr_out combinationally, and pin_oe takes the value tmr_oe had at the previous clock edge. The data latch and direction register keep their values.
- R9: bus_rdata is 0 whenever bus_sel is low. With bus_sel high it shows the addressed register combinationally, including during a write cycle.
- R10: After reset is released, address 2 reads 0 until two rising edges have passed. After that it shows the pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 input, 3 reserved) |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data |
| pin_in | input | W | Pin levels from the pads |
| pin_out | output | W | Value to drive on each pin |
| pin_oe | output | W | Output enable per pin |
| tmr_en | input | W | Per-pin timer takeover |
| tmr_out | input | W | Timer channel output values |
| tmr_oe | input | W | Timer channel output enables |

## Verification
Random direction masks, latch values and pin levels make the per-bit readback mix latch and pin bits in the same word. A swapped mux select or a missing synchronizer stage therefore shows up as a wrong bit. Random timer enables, mixed bit by bit with GPIO pins, separate the override path from the latch and direction path on both pin_out and pin_oe. Directed sequences cover the following:
- the one-edge lag of pin_oe after a direction write;
- the two-edge pin latency at reset release;
- writes to the input and reserved addresses, which must leave every register unchanged.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic [W-1:0] tmr_en,
  input  logic [W-1:0] tmr_out,
  input  logic [W-1:0] tmr_oe
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_IN   = 2'd2;

  logic [W-1:0] dat_q, dir_q, sy1_q, sy2_q, oe_q, rd_mux;
  logic         wr_dat, wr_dir;

  assign wr_dat = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign wr_dir = bus_sel && bus_wr && (bus_addr == A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= '0;
      sy1_q <= '0;
      sy2_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr_dat) dat_q <= bus_wdata;
      if (wr_dir) dir_q <= bus_wdata;
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      oe_q  <= (tmr_en & tmr_oe) | (~tmr_en & dir_q);
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  rd_mux = (dir_q & dat_q) | (~dir_q & sy2_q);
      A_DIR:   rd_mux = dir_q;
      A_IN:    rd_mux = sy2_q;
      default: rd_mux = '0;
    endcase
  end

  assign bus_rdata = bus_sel ? rd_mux : '0;
  assign pin_out   = (tmr_en & tmr_out) | (~tmr_en & dat_q);
  assign pin_oe    = oe_q;

  logic [1:0] edges_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges_q <= '0;
    else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_DIR) |=> (dir_q == $past(bus_wdata)));

  assert_oe_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en == '0) |=> (pin_oe == $past(dir_q)));

  assert_rdata_out_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == A_DATA) |-> ((bus_rdata & dir_q) == (dat_q & dir_q)));

  assert_in_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == A_IN && edges_q == 2'd2) |-> (bus_rdata == $past(pin_in, 2)));

  assert_in_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_IN) |=> ($stable(dat_q) && $stable(dir_q)));

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 2'd3) |-> (bus_rdata == '0));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata, pin_in = 0, pin_out, pin_oe;
  logic [W-1:0] tmr_en = 0, tmr_out = 0, tmr_oe = 0;
  int unsigned n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port #(.W(W)) i_gpio_port (.*);

  logic [W-1:0] m_dat, m_dir, m_s1, m_s2, m_oe;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dat <= 0; m_dir <= 0; m_s1 <= 0; m_s2 <= 0; m_oe <= 0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == 2'd0) m_dat <= bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 2'd1) m_dir <= bus_wdata;
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      m_oe <= (tmr_en & tmr_oe) | (~tmr_en & m_dir);
    end
  end

  function automatic logic [W-1:0] f_rd(logic s, logic [1:0] a, logic [W-1:0] dir,
                                        logic [W-1:0] dat, logic [W-1:0] syn);
    if (!s) return '0;
    case (a)
      2'd0: return (dir & dat) | (~dir & syn);
      2'd1: return dir;
      2'd2: return syn;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] f_pout(logic [W-1:0] en, logic [W-1:0] t, logic [W-1:0] d);
    return (en & t) | (~en & d);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, string tag, logic [W-1:0] exp);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    pin_in = 8'hFF;
    #1;
    bus_sel = 1; bus_addr = 2'd2; #1;
    chk("R1 input reg in reset", bus_rdata, 8'h00);
    bus_addr = 2'd1; #1;
    chk("R1 dir in reset", bus_rdata, 8'h00);
    chk("R1 oe in reset", pin_oe, 8'h00);
    chk("R1 pin_out in reset", pin_out, 8'h00);
    bus_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_sel = 1; bus_addr = 2'd2;
    @(negedge clk); #1;
    chk("R10 one edge after reset", bus_rdata, 8'h00);
    @(negedge clk); #1;
    chk("R10 two edges after reset", bus_rdata, 8'hFF);
    bus_sel = 0; #1;
    chk("R9 idle rdata", bus_rdata, 8'h00);

    wr(2'd0, 8'hA5);
    chk("R2 pin_out from latch", pin_out, 8'hA5);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h0F;
    @(negedge clk); bus_sel = 0; bus_wr = 0; #1;
    chk("R3 oe before lag edge", pin_oe, 8'h00);
    @(negedge clk); #1;
    chk("R3 oe after lag edge", pin_oe, 8'h0F);
    pin_in = 8'h3C;
    rd(2'd0, "R4 data before sync", 8'hF5);
    rd(2'd0, "R4 data after sync", 8'h35);
    rd(2'd2, "R6 input ignores dir", 8'h3C);

    wr(2'd2, 8'h00);
    rd(2'd1, "R6 dir after input write", 8'h0F);
    rd(2'd0, "R6 data after input write", 8'h35);
    wr(2'd3, 8'hFF);
    rd(2'd3, "R7 reserved reads zero", 8'h00);
    rd(2'd1, "R7 dir after reserved write", 8'h0F);

    @(negedge clk); tmr_en = 8'hF0; tmr_out = 8'h50; tmr_oe = 8'hC0; #1;
    chk("R8 pin_out override", pin_out, 8'h55);
    @(negedge clk); #1;
    chk("R8 oe override", pin_oe, 8'hCF);
    rd(2'd1, "R8 dir kept", 8'h0F);
    rd(2'd2, "R8 input still pins", 8'h3C);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pin_in  = W'($urandom);
      tmr_en  = W'($urandom) & W'($urandom);
      tmr_out = W'($urandom);
      tmr_oe  = W'($urandom);
      bus_sel = ($urandom % 5) != 0;
      bus_wr  = ($urandom % 3) == 0;
      bus_addr = 2'($urandom);
      bus_wdata = W'($urandom);
      #1;
      chk("R4/R6/R7/R9 random rdata", bus_rdata, f_rd(bus_sel, bus_addr, m_dir, m_dat, m_s2));
      chk("R2/R8 random pin_out", pin_out, f_pout(tmr_en, tmr_out, m_dat));
      chk("R3/R8 random pin_oe", pin_oe, m_oe);
    end
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule